// File: doc/BRIEF.md
# Banked Internal Data RAM Controller

This block holds the 128-byte internal scratch memory of an 8-bit microcontroller core. It turns each kind of operand access into one physical byte address in a single storage array. The access kinds are working registers R0..R7, whole bytes by address, bytes reached through a pointer register, single bits and stack push/pop. The core presents one request per cycle as a kind code, a two-bit bank selector, an 8-bit index or address, write data and a bit value. Read results show up on registered outputs after the edge that accepts the request.

Single-bit writes are done as read-modify-write. On the accepting edge the block reads the target byte and builds the new value. On the following edge it writes the byte back. During that second cycle the block reports itself busy and ignores any request.

The block also keeps a 7-bit stack pointer. Pushes increment it before writing and pops read before decrementing. Any access that would reach outside the 128-byte space sets an error flag and writes nothing. The array is not cleared by reset.

Top module: `iram_ctrl`

## Requirements
- R1: After reset, `rd_data` is 00h, and `rd_bit`, `acc_err` and `busy` are 0. The stack pointer starts at 07h, so the first push writes byte 08h.
- R2: Register kinds (code 1 = read, 2 = write) reach byte `8*bank_sel + acc_idx[2:0]`, with `bank_sel` 0..3 choosing banks 0..3. `acc_idx[7:3]` is ignored and raises no error.
- R3: Direct kinds (3 = read, 4 = write) reach byte `acc_idx[6:0]`. They share storage with the register kinds.
- R4: Indirect kinds (5 = read, 6 = write) use the byte held in R0 (`acc_idx[0]`=0) or R1 (`acc_idx[0]`=1) of the active bank as the address. An index with `acc_idx[2:1]` not zero sets `acc_err` and performs no access.
- R5: A direct address, or an indirect pointer value, with bit 7 set sets `acc_err`. It writes nothing and leaves `rd_data` unchanged.
- R6: Bit read (kind 7) of bit address b returns bit `b[2:0]` of byte `20h + b[6:3]` on `rd_bit`.
- R7: Bit set (8), bit clear (9) and bit move (10, which copies `bit_in`) change only the addressed bit. `busy` is high for exactly the one cycle after acceptance, and the byte is rewritten at the end of that cycle.
- R8: A request presented while `busy` is high is ignored. It writes nothing and changes no output or stack state.
- R9: Push (kind 11) increments the pointer and then writes `wr_data` at the new pointer. A push with the pointer at 7Fh sets `acc_err`, writes nothing and keeps the pointer.
- R10: Pop (kind 12) returns the byte at the pointer on `rd_data` and then decrements the pointer, modulo 128.
- R11: A bit kind with bit address 80h or above sets `acc_err` and changes no byte.
- R12: `acc_err` is updated by every accepted request, including idle (kind 0, also used for codes 13..15), so a successful request clears it. `rd_data` changes only on successful byte reads and pops, and `rd_bit` only on successful bit reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_kind | input | 4 | Request kind code |
| bank_sel | input | 2 | Active register bank |
| acc_idx | input | 8 | Register index, byte address or bit address |
| wr_data | input | 8 | Byte to write or push |
| bit_in | input | 1 | Bit value for bit move |
| rd_data | output | 8 | Last byte read or popped |
| rd_bit | output | 1 | Last bit read |
| acc_err | output | 1 | Error of the last accepted request |
| busy | output | 1 | Bit write-back in progress; requests ignored |

## Verification
Two things can land in the same cycle: the write-back half of a bit write, and a new request from the core. The bench provokes this by placing a direct byte write, and in another case a push, in the cycle right after a bit set. A behavioural model drops both requests. Later reads of the targeted byte and of the stack show whether the design wrote anything or moved its pointer.

// File: rtl/iram_pkg.sv
package iram_pkg;
  typedef enum logic [3:0] {
    K_IDLE    = 4'd0,
    K_REG_RD  = 4'd1,
    K_REG_WR  = 4'd2,
    K_DIR_RD  = 4'd3,
    K_DIR_WR  = 4'd4,
    K_IND_RD  = 4'd5,
    K_IND_WR  = 4'd6,
    K_BIT_RD  = 4'd7,
    K_BIT_SET = 4'd8,
    K_BIT_CLR = 4'd9,
    K_BIT_MOV = 4'd10,
    K_PUSH    = 4'd11,
    K_POP     = 4'd12
  } acc_kind_e;

  typedef enum logic [1:0] {
    BOP_SET = 2'd0,
    BOP_CLR = 2'd1,
    BOP_MOV = 2'd2
  } bit_op_e;
endpackage

// File: rtl/iram_array.sv
module iram_array #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // storage is deliberately left out of reset
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int BANKS    = 4,
  parameter int REGS     = 8,
  parameter int BIT_BASE = 32
) (
  input  acc_kind_e                    kind,
  input  logic [$clog2(BANKS)-1:0]     bank,
  input  logic [DW-1:0]                idx,
  input  logic [DW-1:0]                ptr_val,
  input  logic [AW-1:0]                sp,
  output logic [AW-1:0]                ptr_addr,
  output logic [AW-1:0]                phys,
  output logic                         err,
  output logic                         rd_byte,
  output logic                         wr_byte,
  output logic                         rd_bit_op,
  output logic                         wr_bit_op,
  output logic [$clog2(DW)-1:0]        bit_pos,
  output bit_op_e                      bit_op
);
  localparam int RW = $clog2(REGS);
  localparam int PW = $clog2(DW);

  logic [AW-1:0] reg_addr;
  logic [AW-1:0] bit_byte;
  logic [AW:0]   sp_inc;
  logic          hi_bad;
  logic          ptr_bad;
  logic          sel_bad;

  assign reg_addr = AW'({bank, idx[RW-1:0]});
  assign ptr_addr = AW'({bank, {(RW-1){1'b0}}, idx[0]});
  assign bit_byte = AW'(BIT_BASE) + AW'(idx[AW-1:PW]);
  assign sp_inc   = {1'b0, sp} + {{AW{1'b0}}, 1'b1};
  assign hi_bad   = |idx[DW-1:AW];
  assign ptr_bad  = |ptr_val[DW-1:AW];
  assign sel_bad  = |idx[RW-1:1];
  assign bit_pos  = idx[PW-1:0];

  always_comb begin
    phys      = reg_addr;
    err       = 1'b0;
    rd_byte   = 1'b0;
    wr_byte   = 1'b0;
    rd_bit_op = 1'b0;
    wr_bit_op = 1'b0;
    bit_op    = BOP_SET;
    case (kind)
      K_REG_RD: rd_byte = 1'b1;
      K_REG_WR: wr_byte = 1'b1;
      K_DIR_RD, K_DIR_WR: begin
        phys    = idx[AW-1:0];
        err     = hi_bad;
        rd_byte = (kind == K_DIR_RD);
        wr_byte = (kind == K_DIR_WR);
      end
      K_IND_RD, K_IND_WR: begin
        phys    = ptr_val[AW-1:0];
        err     = sel_bad | ptr_bad;
        rd_byte = (kind == K_IND_RD);
        wr_byte = (kind == K_IND_WR);
      end
      K_BIT_RD: begin
        phys      = bit_byte;
        err       = hi_bad;
        rd_bit_op = 1'b1;
      end
      K_BIT_SET, K_BIT_CLR, K_BIT_MOV: begin
        phys      = bit_byte;
        err       = hi_bad;
        wr_bit_op = 1'b1;
        bit_op    = (kind == K_BIT_SET) ? BOP_SET :
                    (kind == K_BIT_CLR) ? BOP_CLR : BOP_MOV;
      end
      K_PUSH: begin
        phys    = sp_inc[AW-1:0];
        err     = sp_inc[AW];
        wr_byte = 1'b1;
      end
      K_POP: begin
        phys    = sp;
        rd_byte = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iram_bit_rmw.sv
module iram_bit_rmw
  import iram_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  start,
  input  logic [AW-1:0]         byte_addr,
  input  logic [$clog2(DW)-1:0] pos,
  input  bit_op_e               op,
  input  logic                  bit_in,
  input  logic [DW-1:0]         cur_byte,
  output logic                  busy,
  output logic                  wb_we,
  output logic [AW-1:0]         wb_addr,
  output logic [DW-1:0]         wb_data
);
  logic          busy_d;
  logic          new_bit;
  logic [DW-1:0] merged;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    case (op)
      BOP_SET: new_bit = 1'b1;
      BOP_CLR: new_bit = 1'b0;
      default: new_bit = bit_in;
    endcase
    merged      = cur_byte;
    merged[pos] = new_bit;
    busy_d      = start;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
    end else begin
      busy <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      addr_q <= byte_addr;
      data_q <= merged;
    end
  end

  assign wb_we   = busy;
  assign wb_addr = addr_q;
  assign wb_data = data_q;

  AST_RMW_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> !busy); // R7
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> !start); // R8
endmodule

// File: rtl/iram_ctrl.sv
module iram_ctrl
  import iram_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int BANKS    = 4,
  parameter int REGS     = 8,
  parameter int BIT_BASE = 32,
  parameter int SP_RESET = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] acc_kind,
  input  logic [1:0] bank_sel,
  input  logic [7:0] acc_idx,
  input  logic [7:0] wr_data,
  input  logic       bit_in,
  output logic [7:0] rd_data,
  output logic       rd_bit,
  output logic       acc_err,
  output logic       busy
);
  localparam int PW = $clog2(DW);

  logic [1:0]    rst_pipe;
  logic          rst_ni;
  acc_kind_e     kind;
  logic          accept;

  logic [AW-1:0] sp_q, sp_d;
  logic [AW-1:0] ptr_addr, phys;
  logic [DW-1:0] ptr_val, cur_byte;
  logic          map_err, rd_byte, wr_byte, rd_bit_op, wr_bit_op;
  logic [PW-1:0] bit_pos;
  bit_op_e       bit_op;

  logic          rmw_start, wb_we;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  logic [DW-1:0] rd_data_d;
  logic          rd_bit_d, err_d;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe[1];

  assign kind   = acc_kind_e'(acc_kind);
  assign accept = !busy;

  iram_addr_map #(
    .AW(AW), .DW(DW), .BANKS(BANKS), .REGS(REGS), .BIT_BASE(BIT_BASE)
  ) u_map (
    .kind      (kind),
    .bank      (bank_sel),
    .idx       (acc_idx),
    .ptr_val   (ptr_val),
    .sp        (sp_q),
    .ptr_addr  (ptr_addr),
    .phys      (phys),
    .err       (map_err),
    .rd_byte   (rd_byte),
    .wr_byte   (wr_byte),
    .rd_bit_op (rd_bit_op),
    .wr_bit_op (wr_bit_op),
    .bit_pos   (bit_pos),
    .bit_op    (bit_op)
  );

  iram_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (ptr_addr),
    .rdata_a (ptr_val),
    .raddr_b (phys),
    .rdata_b (cur_byte)
  );

  assign rmw_start = accept && wr_bit_op && !map_err;

  iram_bit_rmw #(.AW(AW), .DW(DW)) u_rmw (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .start     (rmw_start),
    .byte_addr (phys),
    .pos       (bit_pos),
    .op        (bit_op),
    .bit_in    (bit_in),
    .cur_byte  (cur_byte),
    .busy      (busy),
    .wb_we     (wb_we),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data)
  );

  // single write port: write-back owns it while busy
  always_comb begin
    if (busy) begin
      mem_we    = wb_we;
      mem_waddr = wb_addr;
      mem_wdata = wb_data;
    end else begin
      mem_we    = wr_byte && !map_err;
      mem_waddr = phys;
      mem_wdata = wr_data;
    end
  end

  always_comb begin
    sp_d      = sp_q;
    rd_data_d = rd_data;
    rd_bit_d  = rd_bit;
    err_d     = acc_err;
    if (accept) begin
      err_d = map_err;
      if (!map_err) begin
        if (kind == K_PUSH) sp_d = sp_q + AW'(1);
        if (kind == K_POP)  sp_d = sp_q - AW'(1);
        if (rd_byte)        rd_data_d = cur_byte;
        if (rd_bit_op)      rd_bit_d  = cur_byte[bit_pos];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= AW'(SP_RESET);
      rd_data <= '0;
      rd_bit  <= 1'b0;
      acc_err <= 1'b0;
    end else begin
      sp_q    <= sp_d;
      rd_data <= rd_data_d;
      rd_bit  <= rd_bit_d;
      acc_err <= err_d;
    end
  end

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && kind == K_PUSH && !map_err) |=> (sp_q == $past(sp_q) + AW'(1))); // R9
  AST_PUSH_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && kind == K_PUSH && map_err) |=> $stable(sp_q)); // R9
  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && kind == K_POP) |=> (sp_q == $past(sp_q) - AW'(1))); // R10
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> ($stable(sp_q) && $stable(rd_data) && $stable(acc_err))); // R8
  AST_BIT_ERR_NO_RMW: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && wr_bit_op && map_err) |=> !busy); // R11
endmodule

// File: tb/iram_ctrl_bench.sv
module iram_ctrl_bench;
  import iram_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk;
  logic       rst_n;
  logic [3:0] acc_kind;
  logic [1:0] bank_sel;
  logic [7:0] acc_idx;
  logic [7:0] wr_data;
  logic       bit_in;
  logic [7:0] rd_data;
  logic       rd_bit;
  logic       acc_err;
  logic       busy;

  int    errors;
  int    checks;
  bit    done;
  string cur_tag;
  string chk_tag;

  // reference model state
  logic [7:0] m_mem [0:127];
  int         m_sp;
  logic [7:0] m_rd;
  logic       m_bit;
  logic       m_err;
  logic       m_busy;
  int         m_wb_addr;
  int         m_wb_pos;
  logic       m_wb_val;

  iram_ctrl u_iram_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_kind (acc_kind),
    .bank_sel (bank_sel),
    .acc_idx  (acc_idx),
    .wr_data  (wr_data),
    .bit_in   (bit_in),
    .rd_data  (rd_data),
    .rd_bit   (rd_bit),
    .acc_err  (acc_err),
    .busy     (busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural model, updated on the same edge as the design
  always @(posedge clk) begin
    chk_tag = cur_tag;
    if (!rst_n) begin
      m_sp = 7; m_rd = 8'h00; m_bit = 1'b0; m_err = 1'b0; m_busy = 1'b0;
    end else if (m_busy) begin
      m_mem[m_wb_addr][m_wb_pos] = m_wb_val;
      m_busy = 1'b0;
    end else begin
      int   a;
      logic e;
      logic [7:0] p;
      e = 1'b0;
      a = bank_sel * 8 + acc_idx[2:0];
      p = m_mem[bank_sel * 8 + acc_idx[0]];
      case (acc_kind)
        4'd1: m_rd = m_mem[a];
        4'd2: m_mem[a] = wr_data;
        4'd3: if (acc_idx[7]) e = 1'b1; else m_rd = m_mem[acc_idx[6:0]];
        4'd4: if (acc_idx[7]) e = 1'b1; else m_mem[acc_idx[6:0]] = wr_data;
        4'd5: if (acc_idx[2:1] != 0 || p[7]) e = 1'b1; else m_rd = m_mem[p[6:0]];
        4'd6: if (acc_idx[2:1] != 0 || p[7]) e = 1'b1; else m_mem[p[6:0]] = wr_data;
        4'd7: if (acc_idx[7]) e = 1'b1;
              else m_bit = m_mem[32 + acc_idx[6:3]][acc_idx[2:0]];
        4'd8, 4'd9, 4'd10: begin
          if (acc_idx[7]) e = 1'b1;
          else begin
            m_busy    = 1'b1;
            m_wb_addr = 32 + acc_idx[6:3];
            m_wb_pos  = acc_idx[2:0];
            m_wb_val  = (acc_kind == 4'd8) ? 1'b1 : (acc_kind == 4'd9) ? 1'b0 : bit_in;
          end
        end
        4'd11: if (m_sp == 127) e = 1'b1;
               else begin m_sp = m_sp + 1; m_mem[m_sp] = wr_data; end
        4'd12: begin m_rd = m_mem[m_sp]; m_sp = (m_sp + 127) % 128; end
        default: ;
      endcase
      m_err = e;
    end
  end

  // compare away from the active edge, every cycle
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rd_data !== m_rd || rd_bit !== m_bit || acc_err !== m_err || busy !== m_busy) begin
        errors++;
        $display("FAIL %s: actual rd_data=%02h rd_bit=%b err=%b busy=%b expected rd_data=%02h rd_bit=%b err=%b busy=%b",
                 chk_tag, rd_data, rd_bit, acc_err, busy, m_rd, m_bit, m_err, m_busy);
      end
    end
  end

  task automatic op(input logic [3:0] k, input logic [1:0] b, input logic [7:0] i,
                    input logic [7:0] d, input logic bi, input string t);
    @(negedge clk);
    acc_kind = k; bank_sel = b; acc_idx = i; wr_data = d; bit_in = bi; cur_tag = t;
  endtask

  task automatic idle(input string t);
    op(4'd0, 2'd0, 8'h00, 8'h00, 1'b0, t);
  endtask

  initial begin
    errors = 0; checks = 0; done = 1'b0;
    acc_kind = 4'd0; bank_sel = 2'd0; acc_idx = 8'h00; wr_data = 8'h00; bit_in = 1'b0;
    cur_tag = "R1"; chk_tag = "R1";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle("R1 reset state");

    // fill every location through direct writes (R3)
    for (int a = 0; a < 128; a++) op(4'd4, 2'd0, 8'(a), 8'((a * 37 + 5) & 8'h7F), 1'b0, "R3 fill");
    for (int a = 0; a < 128; a += 9) op(4'd3, 2'd0, 8'(a), 8'h00, 1'b0, "R3 direct read");

    // first push lands at 08h (R1, R9)
    op(4'd11, 2'd0, 8'h00, 8'hA5, 1'b0, "R1 first push");
    op(4'd3, 2'd0, 8'h08, 8'h00, 1'b0, "R1 first push at 08h");
    op(4'd12, 2'd0, 8'h00, 8'h00, 1'b0, "R10 pop back");

    // register banks (R2)
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 8; r++)
        op(4'd2, 2'(b), 8'(r) | 8'hF8, 8'(16 * b + r + 3), 1'b0, "R2 bank write");
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 8; r += 3)
        op(4'd1, 2'(b), 8'(r), 8'h00, 1'b0, "R2 bank read");
    op(4'd3, 2'd0, 8'h13, 8'h00, 1'b0, "R2 bank2 R3 is byte 13h");

    // indirect (R4, R5)
    op(4'd2, 2'd2, 8'h00, 8'h45, 1'b0, "R4 set R0");
    op(4'd2, 2'd2, 8'h01, 8'h6E, 1'b0, "R4 set R1");
    op(4'd6, 2'd2, 8'h00, 8'hC3, 1'b0, "R4 indirect write R0");
    op(4'd5, 2'd2, 8'h01, 8'h00, 1'b0, "R4 indirect read R1");
    op(4'd3, 2'd0, 8'h45, 8'h00, 1'b0, "R4 byte 45h written");
    op(4'd6, 2'd2, 8'h03, 8'hEE, 1'b0, "R4 bad pointer reg");
    op(4'd3, 2'd0, 8'h45, 8'h00, 1'b0, "R4 no write on bad reg");
    op(4'd2, 2'd3, 8'h00, 8'h90, 1'b0, "R5 set high pointer");
    op(4'd6, 2'd3, 8'h00, 8'h11, 1'b0, "R5 high pointer write");
    op(4'd5, 2'd3, 8'h00, 8'h00, 1'b0, "R5 high pointer read");
    op(4'd4, 2'd0, 8'h85, 8'h22, 1'b0, "R5 direct high write");
    op(4'd3, 2'd0, 8'h05, 8'h00, 1'b0, "R5 alias untouched");
    op(4'd3, 2'd0, 8'h10, 8'h00, 1'b0, "R12 error cleared");

    // bits (R6, R7, R11)
    for (int b = 0; b < 128; b += 13) op(4'd7, 2'd0, 8'(b), 8'h00, 1'b0, "R6 bit read");
    op(4'd8, 2'd0, 8'h3A, 8'h00, 1'b0, "R7 bit set");
    idle("R7 write-back");
    op(4'd3, 2'd0, 8'h27, 8'h00, 1'b0, "R7 byte after set");
    op(4'd9, 2'd0, 8'h3A, 8'h00, 1'b0, "R7 bit clear");
    idle("R7 write-back");
    op(4'd7, 2'd0, 8'h3A, 8'h00, 1'b0, "R7 bit after clear");
    op(4'd10, 2'd0, 8'h00, 8'h00, 1'b1, "R7 bit move one");
    idle("R7 write-back");
    op(4'd10, 2'd0, 8'h7F, 8'h00, 1'b0, "R7 bit move zero");
    idle("R7 write-back");
    op(4'd3, 2'd0, 8'h20, 8'h00, 1'b0, "R7 byte 20h");
    op(4'd3, 2'd0, 8'h2F, 8'h00, 1'b0, "R7 byte 2Fh");
    op(4'd8, 2'd0, 8'h83, 8'h00, 1'b0, "R11 bit address high");
    op(4'd7, 2'd0, 8'hF0, 8'h00, 1'b0, "R11 bit read high");
    op(4'd3, 2'd0, 8'h20, 8'h00, 1'b0, "R11 byte 20h untouched");

    // collision with write-back (R8)
    op(4'd8, 2'd0, 8'h45, 8'h00, 1'b0, "R8 bit set");
    op(4'd4, 2'd0, 8'h50, 8'h99, 1'b0, "R8 write during busy");
    op(4'd3, 2'd0, 8'h50, 8'h00, 1'b0, "R8 byte 50h kept");
    op(4'd3, 2'd0, 8'h28, 8'h00, 1'b0, "R8 bit set landed");
    op(4'd9, 2'd0, 8'h45, 8'h00, 1'b0, "R8 bit clear");
    op(4'd11, 2'd0, 8'h00, 8'h77, 1'b0, "R8 push during busy");
    op(4'd12, 2'd0, 8'h00, 8'h00, 1'b0, "R8 stack unmoved");

    // stack to the top (R9, R10)
    for (int n = 0; n < 121; n++) op(4'd11, 2'd0, 8'h00, 8'(n + 1), 1'b0, "R9 push");
    op(4'd11, 2'd0, 8'h00, 8'hEE, 1'b0, "R9 push when full");
    op(4'd3, 2'd0, 8'h7F, 8'h00, 1'b0, "R9 top byte kept");
    for (int n = 0; n < 4; n++) op(4'd12, 2'd0, 8'h00, 8'h00, 1'b0, "R10 pop");
    op(4'd15, 2'd0, 8'h00, 8'h00, 1'b0, "R12 unused code idle");
    idle("R12 idle");
    idle("R12 idle");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule